// File: doc/BRIEF.md
# UART Register and Interrupt Interface

This block is the software-facing half of a simple serial port. A host reads and writes four 32-bit word registers through a plain strobe-based register port. The registers are a control word, a receive-data port, a transmit-data port and a status word. Behind them sit a transmit FIFO and a receive FIFO. The block passes the framing configuration and the transmit characters to a separate serializer. It accepts received characters from a separate deserializer.

The status word gathers the FIFO empty and full flags, a selectable FIFO fill level and the two modem-line inputs. It also holds two sticky pending flags, one per direction, which software clears by writing 1. The block sets receive-pending while receive data waits. It sets transmit-pending while the transmit FIFO is below half full. Each pending flag is gated by its own enable bit, and the two gated flags together drive a single level-high interrupt line.

Top module: `uart_regif`

## Requirements
- R1: After reset the control word is 0, both FIFOs are empty, `reg_rdata` is 0, `irq` is low and `tx_valid` is low.
- R2: The control word is at byte offset 0x0 and reads back masked with 0x001CC077. Its fields are: bits 1:0 word length (`cfg_word_len`), bit 2 two stop bits (`cfg_two_stop`), bits 6:4 parity mode (`cfg_parity`), bit 14 level source, bit 15 enable (`cfg_enable`), bit 18 receive interrupt enable, bit 19 transmit interrupt enable and bit 20 loopback (`cfg_loopback`). The configuration outputs follow the stored fields.
- R3: A write to offset 0x8 queues `reg_wdata[7:0]` in the transmit FIFO. While the FIFO is non-empty and the enable bit is 1, `tx_valid` is high and `tx_data` shows the oldest character. A `tx_pop` removes that character. A `tx_pop` while `tx_valid` is low has no effect.
- R4: A transmit write while the transmit FIFO holds TX_DEPTH characters is discarded.
- R5: `rx_push` stores `rx_data` in the receive FIFO, and the push is dropped if the FIFO holds RX_DEPTH characters. A read of offset 0x4 returns the oldest character in bits 7:0, with bits 31:8 zero, and removes it. A read of an empty receive FIFO returns 0. A write to offset 0x4 has no effect.
- R6: The status word is at offset 0xC. Bit 5 is receive FIFO empty, bit 6 is transmit FIFO full, bit 7 is `cts_in`, bit 8 is `rts_in` and bit 10 is transmit FIFO empty. All other bits are 0, except those named in R7 and R8.
- R7: Status bits 16:11 give the transmit FIFO count when control bit 14 is 1. They give the receive FIFO count when control bit 14 is 0.
- R8: Status bit 0 (receive pending) becomes 1 on the cycle after the receive FIFO is non-empty. Status bit 1 (transmit pending) becomes 1 on the cycle after the transmit count is below TX_DEPTH/2. Writing 1 to either bit clears it, unless its condition still holds. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly while (status bit 0 and control bit 18) or (status bit 1 and control bit 19) are both 1.
- R10: Read data appears on `reg_rdata` on the cycle after the `reg_rd` strobe. Reads of offset 0x8 return 0, and `reg_rdata` is 0 on any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset; bits 3:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 1 | Level-high interrupt |
| cfg_enable | output | 1 | Port enable |
| cfg_loopback | output | 1 | Loopback select for the serializer pair |
| cfg_word_len | output | 2 | Character length code |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_parity | output | 3 | Parity mode code |
| tx_data | output | 8 | Oldest transmit character |
| tx_valid | output | 1 | Transmit character available |
| tx_pop | input | 1 | Serializer takes the character |
| rx_data | input | 8 | Received character |
| rx_push | input | 1 | Deserializer delivers a character |
| cts_in | input | 1 | Clear-to-send line state |
| rts_in | input | 1 | Request-to-send line state |

## Verification
Read data is due one cycle after the read strobe. FIFO contents, counts and flags move one cycle after a push, a pop or a register write. Pending flags follow the FIFO state of the previous cycle. `irq` changes in the same cycle as the pending flags or the enable bits it combines. The bench drives inputs and samples outputs at the falling edge. Its queue-based model advances by exactly one rising edge per step, so every output is compared in the first cycle it is due. That comparison covers the two-step pending behaviour after a write-one-to-clear.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
    localparam int REG_W  = 32;
    localparam int CHAR_W = 8;
    localparam int LVL_W  = 6;

    localparam logic [1:0] IDX_CTL  = 2'd0;
    localparam logic [1:0] IDX_RXD  = 2'd1;
    localparam logic [1:0] IDX_TXD  = 2'd2;
    localparam logic [1:0] IDX_STAT = 2'd3;

    localparam int CTL_LVL_SEL = 14;
    localparam int CTL_EN      = 15;
    localparam int CTL_RXIE    = 18;
    localparam int CTL_TXIE    = 19;
    localparam int CTL_LOOP    = 20;
    localparam logic [REG_W-1:0] CTL_WMASK = 32'h001C_C077;

    localparam int ST_RXP   = 0;
    localparam int ST_TXP   = 1;
    localparam int ST_RXE   = 5;
    localparam int ST_TXF   = 6;
    localparam int ST_CTS   = 7;
    localparam int ST_RTS   = 8;
    localparam int ST_TXE   = 10;
    localparam int ST_LVL_LO = 11;

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] rdata;
    } regs_t;

    typedef struct packed {
        logic rx;
        logic tx;
    } pend_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CW'(DEPTH));
    assign count   = q.cnt;
    assign rdata   = mem[q.rd];
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    always_comb begin
        d = q;
        if (do_push) d.wr = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        if (do_pop)  d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= wdata;
    end
endmodule

// File: rtl/uart_pend_irq.sv
module uart_pend_irq
    import uart_regif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_cond,
    input  logic tx_cond,
    input  logic rx_clr,
    input  logic tx_clr,
    input  logic rx_ie,
    input  logic tx_ie,
    output logic rx_pend,
    output logic tx_pend,
    output logic irq
);
    pend_t q, d;

    always_comb begin
        d.rx = (q.rx & ~rx_clr) | rx_cond;
        d.tx = (q.tx & ~tx_clr) | tx_cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_pend = q.rx;
    assign tx_pend = q.tx;
    assign irq     = (q.rx & rx_ie) | (q.tx & tx_ie);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              cfg_enable,
    output logic              cfg_loopback,
    output logic [1:0]        cfg_word_len,
    output logic              cfg_two_stop,
    output logic [2:0]        cfg_parity,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_pop,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_push,
    input  logic              cts_in,
    input  logic              rts_in
);
    localparam int TXCW = $clog2(TX_DEPTH + 1);
    localparam int RXCW = $clog2(RX_DEPTH + 1);

    regs_t q, d;

    logic [1:0]        idx;
    logic              tx_wr, rx_rd, stat_wr;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [TXCW-1:0]   tx_count;
    logic [RXCW-1:0]   rx_count;
    logic [CHAR_W-1:0] rx_head;
    logic              tx_pop_eff;
    logic              rx_pend, tx_pend;
    logic [LVL_W-1:0]  level;
    logic [REG_W-1:0]  status;

    assign idx     = reg_addr[3:2];
    assign tx_wr   = reg_wr & (idx == IDX_TXD);
    assign rx_rd   = reg_rd & (idx == IDX_RXD);
    assign stat_wr = reg_wr & (idx == IDX_STAT);

    assign tx_valid   = ~tx_empty & q.ctl[CTL_EN];
    assign tx_pop_eff = tx_pop & tx_valid;

    uart_fifo #(.DEPTH(TX_DEPTH), .WIDTH(CHAR_W)) i_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_wr),
        .wdata (reg_wdata[CHAR_W-1:0]),
        .pop   (tx_pop_eff),
        .rdata (tx_data),
        .empty (tx_empty),
        .full  (tx_full),
        .count (tx_count)
    );

    uart_fifo #(.DEPTH(RX_DEPTH), .WIDTH(CHAR_W)) i_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_data),
        .pop   (rx_rd),
        .rdata (rx_head),
        .empty (rx_empty),
        .full  (rx_full),
        .count (rx_count)
    );

    uart_pend_irq i_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_cond (~rx_empty),
        .tx_cond (tx_count < TXCW'(TX_DEPTH / 2)),
        .rx_clr  (stat_wr & reg_wdata[ST_RXP]),
        .tx_clr  (stat_wr & reg_wdata[ST_TXP]),
        .rx_ie   (q.ctl[CTL_RXIE]),
        .tx_ie   (q.ctl[CTL_TXIE]),
        .rx_pend (rx_pend),
        .tx_pend (tx_pend),
        .irq     (irq)
    );

    assign level = q.ctl[CTL_LVL_SEL] ? LVL_W'(tx_count) : LVL_W'(rx_count);

    always_comb begin
        status                            = '0;
        status[ST_RXP]                    = rx_pend;
        status[ST_TXP]                    = tx_pend;
        status[ST_RXE]                    = rx_empty;
        status[ST_TXF]                    = tx_full;
        status[ST_CTS]                    = cts_in;
        status[ST_RTS]                    = rts_in;
        status[ST_TXE]                    = tx_empty;
        status[ST_LVL_LO+LVL_W-1:ST_LVL_LO] = level;
    end

    always_comb begin
        d       = q;
        d.rdata = '0;
        if (reg_wr && idx == IDX_CTL) d.ctl = reg_wdata & CTL_WMASK;
        if (reg_rd) begin
            case (idx)
                IDX_CTL:  d.rdata = q.ctl;
                IDX_RXD:  d.rdata = rx_empty ? '0 : REG_W'(rx_head);
                IDX_STAT: d.rdata = status;
                default:  d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_rdata    = q.rdata;
    assign cfg_enable   = q.ctl[CTL_EN];
    assign cfg_loopback = q.ctl[CTL_LOOP];
    assign cfg_word_len = q.ctl[1:0];
    assign cfg_two_stop = q.ctl[2];
    assign cfg_parity   = q.ctl[6:4];

    logic unused_ok;
    assign unused_ok = rx_full;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        irq,
    input logic        tx_valid,
    input logic        tx_pop,
    input logic        cfg_enable,
    input logic        rx_empty,
    input logic        tx_full,
    input logic        rx_pend,
    input logic        tx_pend
);
    p_txvalid_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> cfg_enable);

    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && reg_wr && reg_addr[3:2] == 2'd2 && !(tx_pop && tx_valid)) |=> tx_full);

    p_rd_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr[3:2] == 2'd1 && rx_empty) |=> (reg_rdata == 32'd0));

    p_rx_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_empty |=> rx_pend);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_pend || tx_pend));

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == 32'd0));
endmodule

bind uart_regif uart_regif_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .tx_valid   (tx_valid),
    .tx_pop     (tx_pop),
    .cfg_enable (cfg_enable),
    .rx_empty   (rx_empty),
    .tx_full    (tx_full),
    .rx_pend    (rx_pend),
    .tx_pend    (tx_pend)
);

// File: tb/test_uart_regif.sv
module test_uart_regif;
    localparam int TXD = 16;
    localparam int RXD = 16;
    localparam logic [31:0] MASK = 32'h001C_C077;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq, cfg_enable, cfg_loopback, cfg_two_stop;
    logic [1:0]  cfg_word_len;
    logic [2:0]  cfg_parity;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_pop = 0;
    logic [7:0]  rx_data = 0;
    logic        rx_push = 0;
    logic        cts_in = 0, rts_in = 0;

    always #5 clk = ~clk;

    uart_regif #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_uart_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .cfg_enable(cfg_enable), .cfg_loopback(cfg_loopback),
        .cfg_word_len(cfg_word_len), .cfg_two_stop(cfg_two_stop),
        .cfg_parity(cfg_parity), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
        .cts_in(cts_in), .rts_in(rts_in)
    );

    // Reference model state (register values as seen after the last edge)
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [31:0] m_ctl = 0;
    bit          m_rxp = 0, m_txp = 0;
    logic [31:0] m_rdata = 0;
    string       m_rtag = "R1";

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    task automatic cyc(input bit wr, input bit rd, input logic [3:0] a,
                       input logic [31:0] wd, input bit pop, input bit push,
                       input logic [7:0] rxd, input string tag);
        bit exp_irq, exp_valid, en;
        logic [31:0] st, rv;
        int txn, rxn;
        // compare current outputs
        en        = m_ctl[15];
        exp_irq   = (m_rxp & m_ctl[18]) | (m_txp & m_ctl[19]);
        exp_valid = (txq.size() > 0) && en;
        chk(m_rtag, "reg_rdata", reg_rdata, m_rdata);
        chk("R9", "irq", 32'(irq), 32'(exp_irq));
        chk("R3", "tx_valid", 32'(tx_valid), 32'(exp_valid));
        if (exp_valid) chk("R3", "tx_data", 32'(tx_data), 32'(txq[0]));
        chk("R2", "cfg", {20'd0, cfg_enable, cfg_loopback, cfg_word_len, cfg_two_stop, cfg_parity, 3'd0},
            {20'd0, m_ctl[15], m_ctl[20], m_ctl[1:0], m_ctl[2], m_ctl[6:4], 3'd0});
        // drive
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        tx_pop = pop; rx_push = push; rx_data = rxd;
        // advance model by one rising edge
        txn = txq.size();
        rxn = rxq.size();
        st = 0;
        st[0] = m_rxp; st[1] = m_txp; st[5] = (rxn == 0); st[6] = (txn == TXD);
        st[7] = cts_in; st[8] = rts_in; st[10] = (txn == 0);
        st[16:11] = m_ctl[14] ? 6'(txn) : 6'(rxn);
        rv = 0;
        if (rd) begin
            case (a[3:2])
                2'd0: rv = m_ctl;
                2'd1: rv = (rxn > 0) ? {24'd0, rxq[0]} : 32'd0;
                2'd3: rv = st;
                default: rv = 0;
            endcase
        end
        m_rdata = rv;
        m_rtag  = rd ? tag : "R10";
        m_rxp = (m_rxp & !(wr && a[3:2] == 3 && wd[0])) | (rxn > 0);
        m_txp = (m_txp & !(wr && a[3:2] == 3 && wd[1])) | (txn < TXD / 2);
        if (pop && txn > 0 && en) void'(txq.pop_front());
        if (wr && a[3:2] == 2 && txn < TXD) txq.push_back(wd[7:0]);
        if (rd && a[3:2] == 1 && rxn > 0) void'(rxq.pop_front());
        if (push && rxn < RXD) rxq.push_back(rxd);
        if (wr && a[3:2] == 0) m_ctl = wd & MASK;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, "R10");
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] wd);
        cyc(1, 0, a, wd, 0, 0, 0, "R10");
    endtask

    task automatic rreg(input logic [3:0] a, input string tag);
        cyc(0, 1, a, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "reset rdata", reg_rdata, 0);
        chk("R1", "reset irq", 32'(irq), 0);
        chk("R1", "reset tx_valid", 32'(tx_valid), 0);
        idle(2);
        rreg(4'hC, "R6/R7/R8");          // status after reset: tx pending set
        idle(1);
        // R2: control mask and fields
        wreg(4'h0, 32'hFFFF_FFFF);
        rreg(4'h0, "R2");
        wreg(4'h0, 32'h000C_8003);       // enable, both irq enables, 8-bit code
        rreg(4'h0, "R2");
        // R8: clear while condition still holds
        wreg(4'hC, 32'h3);
        rreg(4'hC, "R8");
        // R3/R4: fill the transmit FIFO past its depth
        for (int i = 0; i < TXD + 4; i++) wreg(4'h8, 32'h140 + i);
        wreg(4'h0, 32'h000C_C003);       // level shows TX count (R7)
        rreg(4'hC, "R4/R6/R7");
        wreg(4'hC, 32'h2);               // R8: clear tx pending, count is full
        idle(1);
        rreg(4'hC, "R8");
        // R3: serializer drains ten characters
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, 0, 0, "R3");
        idle(2);
        rreg(4'hC, "R7/R8");
        // R3: pop ignored while disabled
        wreg(4'h0, 32'h0008_4000);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, 0, "R3");
        rreg(4'hC, "R3/R7");
        // R5: receive path, overfill and drain past empty
        wreg(4'h0, 32'h0004_8000);
        for (int i = 0; i < RXD + 2; i++) cyc(0, 0, 0, 0, 0, 1, 8'hA0 + 8'(i), "R5");
        rreg(4'hC, "R5/R7/R8");
        wreg(4'h4, 32'h55);              // write to receive data ignored
        for (int i = 0; i < RXD + 1; i++) rreg(4'h4, "R5");
        idle(2);
        wreg(4'hC, 32'h1);               // R8: clear rx pending once empty
        idle(1);
        rreg(4'hC, "R8");
        // R10: transmit-data read returns 0
        rreg(4'h8, "R10");
        // R6: modem lines
        cts_in = 1; rts_in = 0;
        rreg(4'hC, "R6");
        cts_in = 0; rts_in = 1;
        rreg(4'hC, "R6");
        // R8: writing 0 has no effect
        cyc(0, 0, 0, 0, 0, 1, 8'h7E, "R8");
        idle(1);
        wreg(4'hC, 32'h0);
        rreg(4'hC, "R8");
        // simultaneous push and read
        cyc(0, 1, 4'h4, 0, 0, 1, 8'h3C, "R5");
        rreg(4'h4, "R5");
        idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule